// File: doc/BRIEF.md
# Two-Wire Command Slave for a Four-Channel Digital Potentiometer

This block is the serial front end of a four-channel digital potentiometer. It oversamples the two-wire bus (clock and data) with the system clock and finds start and stop conditions. It checks an 8-bit device address and acknowledges it. It then decodes a command byte that holds a 4-bit instruction, a 2-bit channel (pot) select and a 2-bit register select. Some commands end after that byte. Others carry a third byte, written by the master or read back from the slave. The step command lets the master move the wiper one position per clock pulse.

Work goes to an external register bank through a request port that uses valid/ready. Each request carries the instruction code, the pot and register selects, the write byte and a step direction. While `req_valid_o` is high and `req_ready_i` is low, the block holds every request field stable. The request is accepted on the first clock where both are high. Writes and transfers are issued on the stop condition. A read request goes out as soon as the command byte has been received, and the bank's `rd_data_i` is captured in the accept cycle. Commands that change a nonvolatile register start a busy window at the stop condition. While it lasts, the device address is not acknowledged, so the master can poll until the write is done.

Top module: `dps_serial_slave`

## Requirements
- R1: A start condition (data falls while clock is high) begins address reception. A stop condition (data rises while clock is high) ends the transaction. A start seen in the middle of any byte, or after an acknowledged command, drops the transaction and its pending request, and address reception starts again.
- R2: The first byte is acknowledged only when it equals {4'b0101, dev_addr_i}, compared MSB first. Any other value gets no acknowledge and the rest of the transaction is ignored.
- R3: The command byte is split as instruction [7:4], pot [3:2] and register [1:0]. The valid instruction codes are 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010. Any other code is not acknowledged and produces no request.
- R4: The codes 1101, 1110, 0001 and 1000 end after the command byte. At the stop condition they issue one request whose req_opc_o equals the instruction code, with the received pot and register selects.
- R5: Codes 1010 (wiper write) and 1100 (register write) take a third byte, which is acknowledged. The request carrying that byte on req_wdata_o is issued at the stop condition, not before.
- R6: Codes 1001 (wiper read) and 1011 (register read) issue a read request right after the command byte. The captured rd_data_i is then shifted out MSB first, one bit per clock-low phase, and the data line is released for the master's acknowledge slot.
- R7: After an acknowledged 0010 command, every clock rising edge before the stop condition issues a request with req_opc_o = 0010 and req_up_o equal to the data level at that edge (1 = toward the high end). This includes the rising edge that opens the stop condition.
- R8: Codes 1100, 1110 and 1000 raise nv_busy_o at the stop condition for BUSY_CYCLES clocks. During that window the address byte is not acknowledged. After it ends, the address is acknowledged again.
- R9: The slave changes its data-line pull only while the clock is low, and it releases the pull at every stop condition.
- R10: While req_valid_o is high and req_ready_i is low, req_valid_o stays high and all request fields hold their values. Exactly one request is counted per accept cycle.
- R11: After reset, sda_pull_o, req_valid_o and nv_busy_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level as seen on the pad |
| sda_i | input | 1 | Bus data level as seen on the pad |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |
| dev_addr_i | input | 4 | Strapped low nibble of the device address |
| req_valid_o | output | 1 | Request to the register bank is valid |
| req_ready_i | input | 1 | Register bank accepts the request |
| req_opc_o | output | 4 | Instruction code of the request |
| req_pot_o | output | 2 | Pot select |
| req_reg_o | output | 2 | Register select |
| req_up_o | output | 1 | Step direction, 1 = up |
| req_wdata_o | output | 8 | Write data byte |
| rd_data_i | input | 8 | Read data from the bank, taken in the accept cycle |
| nv_busy_o | output | 1 | Nonvolatile write window is running |

## Verification
The hardest state to reach from the ports is an address byte that arrives while the nonvolatile window is still open. The bench reaches it by finishing a register write with the bank held not-ready for a while. It then sends the device address at once and expects silence, waits for nv_busy_o to fall, and expects the same address to be acknowledged. A second hard case is a start condition that cuts into a half-sent address byte, or follows an acknowledged command. The bench produces these with its bit-level master tasks and checks that no request leaks out afterwards.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] TYPE_CODE = 4'b0101;

  localparam logic [3:0] OPC_RD_WCR   = 4'b1001;
  localparam logic [3:0] OPC_WR_WCR   = 4'b1010;
  localparam logic [3:0] OPC_RD_DR    = 4'b1011;
  localparam logic [3:0] OPC_WR_DR    = 4'b1100;
  localparam logic [3:0] OPC_DR2WCR   = 4'b1101;
  localparam logic [3:0] OPC_WCR2DR   = 4'b1110;
  localparam logic [3:0] OPC_G_DR2WCR = 4'b0001;
  localparam logic [3:0] OPC_G_WCR2DR = 4'b1000;
  localparam logic [3:0] OPC_STEP     = 4'b0010;

  typedef enum logic [1:0] {FR_SHORT, FR_WRITE, FR_READ, FR_STEP} frame_t;
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_WDATA, ST_RDATA, ST_STEP, ST_HOLD} st_t;
endpackage

// File: rtl/dps_line_sampler.sv
module dps_line_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh   <= '1;
      sda_sh   <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_lvl   = scl_sh[SYNC_STAGES-1];
  assign sda_lvl   = sda_sh[SYNC_STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_evt = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_evt  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/dps_cmd_decode.sv
module dps_cmd_decode
  import dps_pkg::*;
(
  input  logic [3:0] opc,
  output logic       valid,
  output frame_t     frame,
  output logic       nv
);
  always_comb begin
    valid = 1'b1;
    frame = FR_SHORT;
    nv    = 1'b0;
    case (opc)
      OPC_RD_WCR, OPC_RD_DR:  frame = FR_READ;
      OPC_WR_WCR:             frame = FR_WRITE;
      OPC_WR_DR:              begin frame = FR_WRITE; nv = 1'b1; end
      OPC_DR2WCR, OPC_G_DR2WCR: frame = FR_SHORT;
      OPC_WCR2DR, OPC_G_WCR2DR: nv = 1'b1;
      OPC_STEP:               frame = FR_STEP;
      default:                valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/dps_busy_timer.sv
module dps_busy_timer #(
  parameter int BUSY_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/dps_serial_slave.sv
module dps_serial_slave
  import dps_pkg::*;
#(
  parameter int BUSY_CYCLES = 1_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [3:0] dev_addr_i,
  output logic       req_valid_o,
  input  logic       req_ready_i,
  output logic [3:0] req_opc_o,
  output logic [1:0] req_pot_o,
  output logic [1:0] req_reg_o,
  output logic       req_up_o,
  output logic [7:0] req_wdata_o,
  input  logic [7:0] rd_data_i,
  output logic       nv_busy_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BYTE_W);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

  dps_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt)
  );

  st_t               st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] byte_in;
  logic              ack_ok, pending, rd_wait, nv_q;
  logic [3:0]        opc_q;
  logic [1:0]        pot_q, reg_q;
  logic [BYTE_W-1:0] wdata_q;
  frame_t            frame_q;
  logic              dec_valid, dec_nv;
  frame_t            dec_frame;
  logic              nv_start;

  assign byte_in = {shreg[BYTE_W-2:0], sda_lvl};

  dps_cmd_decode u_dec (
    .opc(byte_in[7:4]), .valid(dec_valid), .frame(dec_frame), .nv(dec_nv)
  );

  assign nv_start = stop_evt & pending & nv_q;

  dps_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(nv_start), .busy(nv_busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;
      ack_ok <= 1'b0; pending <= 1'b0; rd_wait <= 1'b0; nv_q <= 1'b0;
      opc_q <= '0; pot_q <= '0; reg_q <= '0; wdata_q <= '0; frame_q <= FR_SHORT;
      sda_pull_o <= 1'b0; req_valid_o <= 1'b0; req_opc_o <= '0;
      req_pot_o <= '0; req_reg_o <= '0; req_up_o <= 1'b0; req_wdata_o <= '0;
    end else begin
      if (req_valid_o && req_ready_i) begin
        req_valid_o <= 1'b0;
        if (rd_wait) begin
          shreg   <= rd_data_i;
          rd_wait <= 1'b0;
        end
      end

      if (start_evt) begin
        st <= ST_ADDR;  bitcnt <= '0;  sda_pull_o <= 1'b0;
        pending <= 1'b0; ack_ok <= 1'b0;
      end else if (stop_evt) begin
        st <= ST_IDLE;  sda_pull_o <= 1'b0;  pending <= 1'b0;
        if (pending) begin
          req_valid_o <= 1'b1; req_opc_o <= opc_q; req_pot_o <= pot_q;
          req_reg_o <= reg_q;  req_wdata_o <= wdata_q; req_up_o <= 1'b0;
        end
      end else if (scl_rise) begin
        case (st)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (bitcnt == ACK_SLOT) begin
              bitcnt <= '0;
              if (!ack_ok) st <= ST_HOLD;
              else if (st == ST_ADDR) st <= ST_CMD;
              else if (st == ST_WDATA) begin st <= ST_HOLD; pending <= 1'b1; end
              else begin
                case (frame_q)
                  FR_WRITE: st <= ST_WDATA;
                  FR_READ:  st <= ST_RDATA;
                  FR_STEP:  st <= ST_STEP;
                  default:  begin st <= ST_HOLD; pending <= 1'b1; end
                endcase
              end
            end else begin
              shreg  <= byte_in;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == LAST_BIT) begin
                if (st == ST_ADDR) begin
                  ack_ok <= (byte_in == {TYPE_CODE, dev_addr_i}) && !nv_busy_o;
                end else if (st == ST_CMD) begin
                  ack_ok <= dec_valid;  opc_q <= byte_in[7:4];
                  pot_q <= byte_in[3:2]; reg_q <= byte_in[1:0];
                  frame_q <= dec_frame;  nv_q <= dec_nv;
                  if (dec_valid && dec_frame == FR_READ) begin
                    req_valid_o <= 1'b1; req_opc_o <= byte_in[7:4];
                    req_pot_o <= byte_in[3:2]; req_reg_o <= byte_in[1:0];
                    req_up_o <= 1'b0; rd_wait <= 1'b1;
                  end
                end else begin
                  ack_ok  <= 1'b1;
                  wdata_q <= byte_in;
                end
              end
            end
          end
          ST_RDATA: begin
            if (bitcnt == ACK_SLOT) begin
              st <= ST_HOLD; bitcnt <= '0;
            end else begin
              shreg  <= {shreg[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
          ST_STEP: begin
            req_valid_o <= 1'b1; req_opc_o <= opc_q; req_pot_o <= pot_q;
            req_reg_o <= reg_q;  req_up_o <= sda_lvl;
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        if (bitcnt == ACK_SLOT && (st == ST_ADDR || st == ST_CMD || st == ST_WDATA))
          sda_pull_o <= ack_ok;
        else if (st == ST_RDATA && bitcnt < ACK_SLOT)
          sda_pull_o <= ~shreg[BYTE_W-1];
        else
          sda_pull_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dps_serial_slave_chk.sv
module dps_serial_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       stop_evt,
  input logic       sda_pull,
  input logic       req_valid,
  input logic       req_ready,
  input logic [3:0] req_opc,
  input logic [1:0] req_pot,
  input logic [1:0] req_reg,
  input logic [7:0] req_wdata,
  input logic       nv_busy
);
  // R9: pull only asserted while bus clock is low
  a_r9_pull_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_lvl);

  // R9: stop releases the line
  a_r9_release_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  // R10: request held under back-pressure
  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_opc) && $stable(req_pot)
      && $stable(req_reg) && $stable(req_wdata));

  // R8: busy window opens only at a stop condition
  a_r8_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_busy) |-> $past(stop_evt));

  // R8: a nonvolatile request comes with the busy window
  a_r8_nv_request_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && (req_opc == 4'b1100 || req_opc == 4'b1110 || req_opc == 4'b1000)
      |-> nv_busy);
endmodule

bind dps_serial_slave dps_serial_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .stop_evt(stop_evt),
  .sda_pull(sda_pull_o), .req_valid(req_valid_o), .req_ready(req_ready_i),
  .req_opc(req_opc_o), .req_pot(req_pot_o), .req_reg(req_reg_o),
  .req_wdata(req_wdata_o), .nv_busy(nv_busy_o)
);

// File: tb/tb_dps_serial_slave.sv
module tb_dps_serial_slave;
  localparam int BUSY = 3000;
  localparam int Q = 10;
  localparam logic [3:0] DEV = 4'b1010;
  localparam logic [7:0] ADDR = {4'b0101, DEV};

  // {command byte, expect ack, expect nonvolatile}
  localparam logic [9:0] VECS [0:6] = '{
    {8'h1D, 1'b1, 1'b0}, {8'hD6, 1'b1, 1'b0}, {8'h3C, 1'b0, 1'b0},
    {8'hE9, 1'b1, 1'b1}, {8'h83, 1'b1, 1'b1}, {8'hF0, 1'b0, 1'b0},
    {8'h00, 1'b0, 1'b0}};

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, ready = 1;
  logic sda_pull, req_valid, req_up, nv_busy;
  logic [3:0] req_opc;
  logic [1:0] req_pot, req_reg;
  logic [7:0] req_wdata, rd_data;
  wire sda_line = sda_m & ~sda_pull;

  int checks = 0, errors = 0, req_cnt = 0;
  logic [3:0] last_opc; logic [1:0] last_pot, last_reg; logic [7:0] last_wdata;
  logic up_log [0:63];
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] bank(input logic [1:0] p, input logic [1:0] r);
    return {p, r, ~p, ~r};
  endfunction
  assign rd_data = bank(req_pot, req_reg);

  dps_serial_slave #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .dev_addr_i(DEV), .req_valid_o(req_valid), .req_ready_i(ready), .req_opc_o(req_opc),
    .req_pot_o(req_pot), .req_reg_o(req_reg), .req_up_o(req_up), .req_wdata_o(req_wdata),
    .rd_data_i(rd_data), .nv_busy_o(nv_busy));

  always @(posedge clk) if (rst_n && req_valid && ready) begin
    up_log[req_cnt[5:0]] <= req_up;
    last_opc <= req_opc; last_pot <= req_pot; last_reg <= req_reg; last_wdata <= req_wdata;
    req_cnt <= req_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic s);
    wt(Q); sda_m = b; wt(Q); scl_m = 1; wt(Q); s = sda_line; wt(Q); scl_m = 0;
  endtask
  task automatic do_start; sda_m = 1; wt(Q); scl_m = 1; wt(2*Q); sda_m = 0; wt(2*Q); scl_m = 0; wt(Q); endtask
  task automatic do_stop;  sda_m = 0; wt(Q); scl_m = 1; wt(2*Q); sda_m = 1; wt(2*Q); endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s); ack = ~s;
  endtask
  task automatic read_byte(output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); d[i] = s; end
    bit_io(1'b1, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++; $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a; logic s; logic [7:0] d; int c0;
    wt(5); rst_n = 1; wt(5);
    // R11 reset state
    chk(!sda_pull && !req_valid && !nv_busy, "R11 reset outputs", {sda_pull, req_valid, nv_busy}, 0);

    // Table of two-byte commands
    for (int v = 0; v < 7; v++) begin
      c0 = req_cnt;
      do_start; send_byte(ADDR, a);
      chk(a, "R2 address ack", a, 1);
      send_byte(VECS[v][9:2], a);
      chk(a == VECS[v][1], "R3 command ack", a, VECS[v][1]);
      do_stop; wt(4);
      if (VECS[v][1]) begin
        chk(req_cnt == c0 + 1 && last_opc == VECS[v][9:6] && last_pot == VECS[v][5:4]
            && last_reg == VECS[v][3:2], "R4 transfer request", {last_opc, last_pot, last_reg}, VECS[v][9:2]);
        chk(nv_busy == VECS[v][0], "R8 busy after transfer", nv_busy, VECS[v][0]);
        wait (!nv_busy); wt(2);
      end else
        chk(req_cnt == c0, "R3 no request for bad code", req_cnt - c0, 0);
    end

    // R2 mismatches
    do_start; send_byte({4'b0101, DEV ^ 4'b0001}, a); do_stop;
    chk(!a, "R2 wrong pins nack", a, 0);
    do_start; send_byte({4'b0110, DEV}, a); do_stop;
    chk(!a, "R2 wrong type nack", a, 0);

    // R5 wiper write
    c0 = req_cnt;
    do_start; send_byte(ADDR, a); send_byte(8'hA4, a); send_byte(8'h5A, a);
    chk(a, "R5 data byte ack", a, 1);
    wt(4); chk(req_cnt == c0, "R5 no request before stop", req_cnt - c0, 0);
    do_stop; wt(4);
    chk(req_cnt == c0 + 1 && last_opc == 4'hA && last_pot == 2'd1 && last_wdata == 8'h5A,
        "R5 write request", {last_opc, last_wdata}, 12'hA5A);
    chk(!nv_busy, "R8 volatile write no busy", nv_busy, 0);

    // R6 reads
    do_start; send_byte(ADDR, a); send_byte(8'h98, a); read_byte(d); do_stop;
    chk(d == bank(2'd2, 2'd0), "R6 wiper read data", d, bank(2'd2, 2'd0));
    do_start; send_byte(ADDR, a); send_byte(8'hB7, a); read_byte(d); do_stop;
    chk(d == bank(2'd1, 2'd3), "R6 register read data", d, bank(2'd1, 2'd3));
    chk(!sda_pull, "R9 released after read", sda_pull, 0);

    // R7 step: pulses up, up, down, then the stop's rising edge counts as down
    c0 = req_cnt;
    do_start; send_byte(ADDR, a); send_byte(8'h24, a);
    chk(a, "R7 step command ack", a, 1);
    bit_io(1'b1, s); bit_io(1'b1, s); bit_io(1'b0, s); do_stop; wt(4);
    chk(req_cnt == c0 + 4, "R7 step count", req_cnt - c0, 4);
    chk(up_log[c0[5:0]] && up_log[c0[5:0]+1] && !up_log[c0[5:0]+2] && !up_log[c0[5:0]+3]
        && last_opc == 4'h2 && last_pot == 2'd1, "R7 step directions", last_opc, 2);

    // R10 back-pressure + R8 polling
    c0 = req_cnt; ready = 0;
    do_start; send_byte(ADDR, a); send_byte(8'hC6, a); send_byte(8'h3F, a); do_stop;
    wt(20);
    chk(req_valid && req_opc == 4'hC && req_wdata == 8'h3F && req_cnt == c0,
        "R10 request held", {req_opc, req_wdata}, 12'hC3F);
    ready = 1; wt(4);
    chk(req_cnt == c0 + 1, "R10 single accept", req_cnt - c0, 1);
    do_start; send_byte(ADDR, a); do_stop;
    chk(!a && nv_busy, "R8 address nack while busy", a, 0);
    wait (!nv_busy); wt(2);
    do_start; send_byte(ADDR, a); do_stop;
    chk(a, "R8 address ack after busy", a, 1);

    // R1 start mid-address byte
    do_start; bit_io(1'b0, s); bit_io(1'b1, s); bit_io(1'b0, s); bit_io(1'b1, s);
    do_start; send_byte(ADDR, a);
    chk(a, "R1 restart mid byte", a, 1);
    // R1 repeated start drops a pending transfer
    c0 = req_cnt;
    send_byte(8'hD0, a);
    do_start; send_byte({4'b0101, ~DEV}, a); do_stop; wt(4);
    chk(req_cnt == c0, "R1 pending dropped by start", req_cnt - c0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule